// File: doc/BRIEF.md
# Binary64 to Integer Converter with Selectable Out-of-Range Handling

This block turns one binary64 floating-point operand into a 32-bit or 64-bit integer placed in a 64-bit result word. A two-bit type code chooses the width and whether the integer is signed or unsigned. A three-bit handling mode chooses what happens when the rounded value does not fit. Conventional saturation clamps to the nearest limit and sends NaN to the most negative value. The second saturating flavour is the same except that NaN gives zero. Modular wrap-around keeps the low bits of the two's-complement integer, as scripting runtimes expect.

The operand is first aligned into a 128-bit integer field with guard and sticky bits and rounded with the selected rounding mode. It is then checked against the type's range, and the flags for the operation are formed. The converter is exact in the integer domain. "Converting the result back and comparing" reduces to range membership of the rounded value, so no second float datapath is needed. When invalid-operation trapping is enabled and an invalid condition arises, the write-enable is withheld so that the destination keeps its old value. Results and flags appear one clock after the valid strobe.

Top module: `fp2int_cvt`

## Requirements
- R1: The rounding code selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Whenever mode bit 2 is 1, rounding is toward zero regardless of the code.
- R2: Type code bit 1 selects 64-bit (1) or 32-bit (0), and bit 0 selects unsigned (1) or signed (0), so 0=s32, 1=u32, 2=s64, 3=u64. An in-range rounded value is written as its two's-complement integer. A 32-bit signed result is sign-extended from bit 31 to 64 bits, and a 32-bit unsigned result is zero-extended.
- R3: In modes 0 to 3, a value above the type's range gives the range maximum and a value below gives the range minimum. The ranges are -2^31..2^31-1, 0..2^32-1, -2^63..2^63-1 and 0..2^64-1. Infinities count as above or below by their sign.
- R4: A NaN operand gives the range minimum in modes 0 and 1, and zero in modes 2 and 3.
- R5: In modes 4 and 5, an infinity, a NaN, or a rounded magnitude of 2^128 or more gives zero. Otherwise the low 64 bits of the rounded value as a signed 128-bit integer are kept, and for 32-bit types only the low 32 bits, then extended as in R2.
- R6: When the operand is NaN or the rounded value lies outside the type's range, the overflow and invalid-conversion flags are set and the inexact and rounded-up flags are 0.
- R7: Otherwise the inexact flag is set when the operand has a nonzero fraction, and the rounded-up flag is set when rounding increased the magnitude.
- R8: An operand with all-ones exponent, nonzero fraction and fraction bit 51 equal to 0 is a signaling NaN and raises the signaling-NaN flag (together with R6).
- R9: With the trap-enable input at 1 and either invalid flag set, the write-enable stays 0, the result output keeps its old value, and the inexact and rounded-up flags are 0. The invalid flags are still reported.
- R10: Modes 6 and 7 are illegal. They raise the bad-mode flag, keep the write-enable at 0 and leave every other flag at 0.
- R11: Outputs change in the cycle after a valid strobe. In a cycle after no strobe, write-enable and all flags are 0 and the result holds.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 64 | binary64 operand |
| in_ty | input | 2 | Integer type code (R2) |
| in_mode | input | 3 | Out-of-range handling mode |
| in_rm | input | 2 | Rounding code (R1) |
| in_trap_en | input | 1 | Invalid-operation trap enable |
| out_res | output | 64 | Integer result, held between writes |
| out_we | output | 1 | Destination write-enable |
| out_ovf | output | 1 | Overflow indication |
| out_inv_cvt | output | 1 | Invalid-conversion flag |
| out_inv_snan | output | 1 | Signaling-NaN flag |
| out_inexact | output | 1 | Inexact flag |
| out_rnd_up | output | 1 | Rounded-up flag |
| out_bad_mode | output | 1 | Illegal mode indication |

## Verification
The bench builds the block with its default parameters: 11 exponent bits, 52 fraction bits, a 64-bit result word, a 128-bit wrap field and 64 fraction bits below the integer point. With these values every boundary the block has is reachable with ordinary operands: the 2^31, 2^32, 2^63 and 2^64 type limits, the 2^128 wrap cut-off, and the point where the whole significand falls below the guard bit. Random operands are drawn with exponents steered onto those boundaries, onto exact half-way ties, onto subnormals and onto NaN and infinity encodings. Directed cases fix the expected bit patterns of the limits.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  parameter int EXP_W  = 11;
  parameter int FRAC_W = 52;
  parameter int WORD_W = 64;
  parameter int ACC_W  = 128;
  parameter int FX_W   = 64;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int HALF_W = WORD_W / 2;
  localparam int WIN_W  = ACC_W + FX_W;
  localparam int SH_W   = $clog2(WIN_W);
  localparam int SW_W   = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_ZERO  = 2'b01,
    RM_CEIL  = 2'b10,
    RM_FLOOR = 2'b11
  } rm_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic inf;
    logic snan;
    logic huge;
  } cls_t;
endpackage

// File: rtl/fp2int_align.sv
module fp2int_align
  import fp2int_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  output cls_t              cls,
  output logic [ACC_W-1:0]  ipart,
  output logic              guard,
  output logic              sticky
);
  localparam int ZERO_SH = BIAS + FRAC_W;
  localparam logic signed [EXP_W+1:0] HUGE_SH = (EXP_W+2)'(ACC_W - SIG_W);
  localparam logic signed [EXP_W+1:0] TINY_SH = -(EXP_W+2)'(FX_W);
  localparam logic signed [EXP_W+1:0] ZSH_S   = (EXP_W+2)'(ZERO_SH);
  localparam logic signed [EXP_W+1:0] FXW_S   = (EXP_W+2)'(FX_W);

  logic [EXP_W-1:0]        ef;
  logic [EXP_W-1:0]        ef_eff;
  logic [FRAC_W-1:0]       fr;
  logic [SIG_W-1:0]        sig;
  logic signed [EXP_W+1:0] sh;
  logic signed [EXP_W+1:0] lsh_s;
  logic [SH_W-1:0]         lsh;
  logic [WIN_W-1:0]        win;
  logic                    special;
  logic                    tiny;

  always_comb begin
    ef      = op[WORD_W-2 -: EXP_W];
    fr      = op[FRAC_W-1:0];
    special = &ef;
    sig     = {(ef != '0), fr};
    ef_eff  = (ef == '0) ? EXP_W'(1) : ef;
    sh      = $signed({2'b00, ef_eff}) - ZSH_S;
    lsh_s   = sh + FXW_S;
    lsh     = lsh_s[SH_W-1:0];
    tiny    = sh < TINY_SH;

    cls.sign = op[WORD_W-1];
    cls.inf  = special & (fr == '0);
    cls.nan  = special & (fr != '0);
    cls.snan = special & (fr != '0) & ~fr[FRAC_W-1];
    cls.huge = ~special & (sh > HUGE_SH);

    win = {{(WIN_W-SIG_W){1'b0}}, sig} << lsh;

    if (special || cls.huge) begin
      ipart  = '0;
      guard  = 1'b0;
      sticky = 1'b0;
    end else if (tiny) begin
      ipart  = '0;
      guard  = 1'b0;
      sticky = |sig;
    end else begin
      ipart  = win[WIN_W-1 -: ACC_W];
      guard  = win[FX_W-1];
      sticky = |win[FX_W-2:0];
    end
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
(
  input  logic [ACC_W-1:0] ipart,
  input  logic             guard,
  input  logic             sticky,
  input  logic             sign,
  input  rm_e              rm,
  output logic [ACC_W-1:0] mag,
  output logic             incr
);
  logic any_frac;

  always_comb begin
    any_frac = guard | sticky;
    unique case (rm)
      RM_NEAR:  incr = guard & (sticky | ipart[0]);
      RM_ZERO:  incr = 1'b0;
      RM_CEIL:  incr = ~sign & any_frac;
      default:  incr = sign & any_frac;
    endcase
    mag = ipart + ACC_W'(incr);
  end
endmodule

// File: rtl/fp2int_fit.sv
module fp2int_fit
  import fp2int_pkg::*;
(
  input  logic [1:0]        ty,
  input  logic [2:0]        mode,
  input  cls_t              cls,
  input  logic [ACC_W-1:0]  mag,
  output logic [WORD_W-1:0] res,
  output logic              in_rng
);
  logic              uns;
  logic              wide;
  logic [SW_W-1:0]   width;
  logic [ACC_W-1:0]  thr;
  logic [ACC_W-1:0]  twos;
  logic [WORD_W-1:0] lim_min;
  logic [WORD_W-1:0] lim_max;
  logic [WORD_W-1:0] raw;
  logic              above;
  logic              below;
  logic              unbounded;

  always_comb begin
    uns       = ty[0];
    wide      = ty[1];
    width     = wide ? SW_W'(WORD_W) : SW_W'(HALF_W);
    unbounded = cls.inf | cls.huge;

    thr   = uns ? (ACC_W'(1) << width) : (ACC_W'(1) << (width - SW_W'(1)));
    above = ~cls.sign & (unbounded | (mag >= thr));
    below = cls.sign & (unbounded | (uns ? (mag != '0) : (mag > thr)));
    in_rng = ~cls.nan & ~above & ~below;

    twos = cls.sign ? (~mag + ACC_W'(1)) : mag;

    lim_min = uns ? '0 : ~((WORD_W'(1) << (width - SW_W'(1))) - WORD_W'(1));
    lim_max = uns ? ({WORD_W{1'b1}} >> (SW_W'(WORD_W) - width))
                  : ((WORD_W'(1) << (width - SW_W'(1))) - WORD_W'(1));

    if (mode[2]) begin
      raw = (cls.nan | unbounded) ? '0 : twos[WORD_W-1:0];
    end else if (cls.nan) begin
      raw = mode[1] ? '0 : lim_min;
    end else if (above) begin
      raw = lim_max;
    end else if (below) begin
      raw = lim_min;
    end else begin
      raw = twos[WORD_W-1:0];
    end

    if (wide) begin
      res = raw;
    end else if (uns) begin
      res = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end else begin
      res = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fp2int_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_op,
  input  logic [1:0]        in_ty,
  input  logic [2:0]        in_mode,
  input  logic [1:0]        in_rm,
  input  logic              in_trap_en,
  output logic [WORD_W-1:0] out_res,
  output logic              out_we,
  output logic              out_ovf,
  output logic              out_inv_cvt,
  output logic              out_inv_snan,
  output logic              out_inexact,
  output logic              out_rnd_up,
  output logic              out_bad_mode
);
  cls_t              cls;
  logic [ACC_W-1:0]  ipart;
  logic [ACC_W-1:0]  mag;
  logic              guard;
  logic              sticky;
  logic              incr;
  logic              in_rng;
  rm_e               rm_eff;
  logic [WORD_W-1:0] res_d;

  logic              bad;
  logic              cvi;
  logic              blk;
  logic              go;
  logic              we_d;
  logic              ovf_d;
  logic              cvi_d;
  logic              snan_d;
  logic              inx_d;
  logic              rup_d;
  logic              bad_d;

  fp2int_align u_align (
    .op     (in_op),
    .cls    (cls),
    .ipart  (ipart),
    .guard  (guard),
    .sticky (sticky)
  );

  always_comb begin
    rm_eff = (in_mode[2] || (in_rm == RM_ZERO)) ? RM_ZERO : rm_e'(in_rm);
  end

  fp2int_round u_round (
    .ipart  (ipart),
    .guard  (guard),
    .sticky (sticky),
    .sign   (cls.sign),
    .rm     (rm_eff),
    .mag    (mag),
    .incr   (incr)
  );

  fp2int_fit u_fit (
    .ty     (in_ty),
    .mode   (in_mode),
    .cls    (cls),
    .mag    (mag),
    .res    (res_d),
    .in_rng (in_rng)
  );

  // next-state
  always_comb begin
    bad    = in_mode[2] & in_mode[1];
    cvi    = cls.nan | ~in_rng;
    blk    = in_trap_en & (cvi | cls.snan);
    go     = in_vld & ~bad;
    we_d   = go & ~blk;
    ovf_d  = go & cvi;
    cvi_d  = go & cvi;
    snan_d = go & cls.snan;
    inx_d  = we_d & ~cvi & (guard | sticky);
    rup_d  = we_d & ~cvi & incr;
    bad_d  = in_vld & bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_res <= '0;
    end else if (we_d) begin
      out_res <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_we       <= 1'b0;
      out_ovf      <= 1'b0;
      out_inv_cvt  <= 1'b0;
      out_inv_snan <= 1'b0;
      out_inexact  <= 1'b0;
      out_rnd_up   <= 1'b0;
      out_bad_mode <= 1'b0;
    end else begin
      out_we       <= we_d;
      out_ovf      <= ovf_d;
      out_inv_cvt  <= cvi_d;
      out_inv_snan <= snan_d;
      out_inexact  <= inx_d;
      out_rnd_up   <= rup_d;
      out_bad_mode <= bad_d;
    end
  end
endmodule

// File: rtl/fp2int_chk.sv
module fp2int_chk
  import fp2int_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [1:0]        in_ty,
  input logic [2:0]        in_mode,
  input logic              in_trap_en,
  input logic [WORD_W-1:0] out_res,
  input logic              out_we,
  input logic              out_ovf,
  input logic              out_inv_cvt,
  input logic              out_inv_snan,
  input logic              out_inexact,
  input logic              out_rnd_up,
  input logic              out_bad_mode
);
  a_r2_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && $past(in_ty) == 2'd0) |-> out_res[WORD_W-1:HALF_W] == {HALF_W{out_res[HALF_W-1]}});

  a_r2_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && $past(in_ty) == 2'd1) |-> out_res[WORD_W-1:HALF_W] == '0);

  a_r6_no_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_inv_cvt |-> (!out_inexact && !out_rnd_up));

  a_r8_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    out_inv_snan |-> out_inv_cvt);

  a_r9_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_inv_cvt || out_inv_snan) && $past(in_trap_en)) |-> (!out_we && !out_inexact && !out_rnd_up));

  a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_vld) && $past(in_mode[2:1]) == 2'b11) |-> (out_bad_mode && !out_we && !out_ovf && !out_inv_snan));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> (!out_we && !out_ovf && !out_inexact && !out_bad_mode));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |-> $stable(out_res));
endmodule

bind fp2int_cvt fp2int_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_vld       (in_vld),
  .in_ty        (in_ty),
  .in_mode      (in_mode),
  .in_trap_en   (in_trap_en),
  .out_res      (out_res),
  .out_we       (out_we),
  .out_ovf      (out_ovf),
  .out_inv_cvt  (out_inv_cvt),
  .out_inv_snan (out_inv_snan),
  .out_inexact  (out_inexact),
  .out_rnd_up   (out_rnd_up),
  .out_bad_mode (out_bad_mode)
);

// File: tb/sim_fp2int_cvt.sv
`timescale 1ns/1ps
module sim_fp2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [63:0] in_op;
  logic [1:0]  in_ty;
  logic [2:0]  in_mode;
  logic [1:0]  in_rm;
  logic        in_trap_en;
  logic [63:0] out_res;
  logic        out_we, out_ovf, out_inv_cvt, out_inv_snan;
  logic        out_inexact, out_rnd_up, out_bad_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] last_res = '0;

  always #10 clk = ~clk;

  fp2int_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_ty(in_ty),
    .in_mode(in_mode), .in_rm(in_rm), .in_trap_en(in_trap_en),
    .out_res(out_res), .out_we(out_we), .out_ovf(out_ovf),
    .out_inv_cvt(out_inv_cvt), .out_inv_snan(out_inv_snan),
    .out_inexact(out_inexact), .out_rnd_up(out_rnd_up), .out_bad_mode(out_bad_mode)
  );

  typedef struct packed {
    logic [63:0] res;
    logic we, ovf, cvi, sn, xx, fr, ill;
  } exp_t;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference built from the requirement text, by remainder comparison.
  function automatic exp_t ref_conv(logic [63:0] x, logic [1:0] ty, logic [2:0] md,
                                    logic [1:0] rm, logic inv);
    exp_t o;
    logic s; logic [10:0] e; logic [51:0] f; logic [127:0] m;
    logic nan, inf, big, up, inr;
    logic [127:0] ip, fb, half, mg;
    logic signed [129:0] v, mn, mx, sel;
    int ex, r, cat;
    o = '0;
    s = x[63]; e = x[62:52]; f = x[51:0];
    nan = (e == 11'h7FF) && (f != 0);
    inf = (e == 11'h7FF) && (f == 0);
    if (md[2:1] == 2'b11) begin o.ill = 1; return o; end
    o.sn = nan && !f[51];
    m = (e == 0) ? {76'b0, f} : {75'b0, 1'b1, f};
    ex = ((e == 0) ? 1 : int'(e)) - 1075;
    big = 0; ip = 0; cat = 0;
    if (!nan && !inf) begin
      if (ex > 75) big = 1;
      else if (ex >= 0) ip = m << ex;
      else begin
        r = -ex;
        if (r > 60) cat = (m != 0) ? 1 : 0;
        else begin
          ip = m >> r;
          fb = m & ((128'd1 << r) - 1);
          half = 128'd1 << (r - 1);
          cat = (fb == 0) ? 0 : (fb < half) ? 1 : (fb == half) ? 2 : 3;
        end
      end
    end
    if (md[2] || rm == 2'b01) up = 0;
    else if (rm == 2'b00) up = (cat == 3) || (cat == 2 && ip[0]);
    else if (rm == 2'b10) up = !s && cat != 0;
    else up = s && cat != 0;
    mg = ip + {127'b0, up};
    v = s ? -$signed({2'b00, mg}) : $signed({2'b00, mg});
    case (ty)
      2'd0: begin mn = -130'sd2147483648; mx = 130'sd2147483647; end
      2'd1: begin mn = 130'sd0; mx = 130'sd4294967295; end
      2'd2: begin mn = -(130'sd1 <<< 63); mx = (130'sd1 <<< 63) - 130'sd1; end
      default: begin mn = 130'sd0; mx = (130'sd1 <<< 64) - 130'sd1; end
    endcase
    inr = !nan && !inf && !big && v >= mn && v <= mx;
    if (!md[2]) begin
      if (nan) sel = md[1] ? 130'sd0 : mn;
      else if (inf || big) sel = s ? mn : mx;
      else if (v < mn) sel = mn;
      else if (v > mx) sel = mx;
      else sel = v;
    end else sel = (nan || inf || big) ? 130'sd0 : v;
    o.res = sel[63:0];
    if (ty == 2'd0) o.res = {{32{o.res[31]}}, o.res[31:0]};
    else if (ty == 2'd1) o.res = {32'b0, o.res[31:0]};
    o.cvi = nan || !inr;
    o.ovf = o.cvi;
    o.xx = !o.cvi && cat != 0;
    o.fr = !o.cvi && up;
    o.we = 1;
    if (inv && (o.cvi || o.sn)) begin o.we = 0; o.xx = 0; o.fr = 0; end
    return o;
  endfunction

  task automatic run(input logic [63:0] op, input logic [1:0] ty, input logic [2:0] md,
                     input logic [1:0] rm, input logic inv, input string tag);
    exp_t ex;
    @(negedge clk);
    in_op = op; in_ty = ty; in_mode = md; in_rm = rm; in_trap_en = inv; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    ex = ref_conv(op, ty, md, rm, inv);
    if (ex.we) last_res = ex.res;
    check(tag, "result", out_res, last_res);
    check("R9", "write-enable", {63'b0, out_we}, {63'b0, ex.we});
    check("R6", "overflow", {63'b0, out_ovf}, {63'b0, ex.ovf});
    check("R6", "invalid-conversion", {63'b0, out_inv_cvt}, {63'b0, ex.cvi});
    check("R8", "signaling-nan", {63'b0, out_inv_snan}, {63'b0, ex.sn});
    check("R7", "inexact", {63'b0, out_inexact}, {63'b0, ex.xx});
    check("R7", "rounded-up", {63'b0, out_rnd_up}, {63'b0, ex.fr});
    check("R10", "bad-mode", {63'b0, out_bad_mode}, {63'b0, ex.ill});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R11", "idle write-enable", {63'b0, out_we}, 64'd0);
    check("R11", "idle flags",
          {57'b0, out_ovf, out_inv_cvt, out_inv_snan, out_inexact, out_rnd_up, out_bad_mode, 1'b0}, 64'd0);
    check("R11", "held result", out_res, last_res);
  endtask

  function automatic logic [63:0] gen_op();
    logic s; logic [10:0] e; logic [51:0] fr; int k;
    s = 1'($urandom % 2);
    fr = {20'($urandom), $urandom};
    e = 11'd1023;
    case ($urandom % 8)
      0: return {$urandom, $urandom};
      1: e = 11'(1021 + $urandom % 72);
      2: begin
        k = $urandom % 20;
        e = 11'(1023 + k);
        fr = (fr & ~((52'd1 << (52 - k)) - 52'd1)) | (52'd1 << (51 - k));
      end
      3: begin e = 11'h7FF; if ($urandom % 3 == 0) fr = '0; end
      4: e = 11'(1023 + (($urandom % 2) ? 30 : 62) + $urandom % 4);
      5: e = 11'(1023 + 124 + $urandom % 8);
      6: e = 11'($urandom % 1030);
      default: e = 11'(1023 + $urandom % 141);
    endcase
    if ($urandom % 5 == 0) fr = ($urandom % 2) ? '0 : '1;
    return {s, e, fr};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_ty = '0; in_mode = '0; in_rm = '0; in_trap_en = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "reset result", out_res, 64'd0);
    check("R12", "reset flags",
          {56'b0, out_we, out_ovf, out_inv_cvt, out_inv_snan, out_inexact, out_rnd_up, out_bad_mode, 1'b0}, 64'd0);
    rst_n = 1'b1;
    idle_check();

    // R1 rounding selection
    run(64'h4004000000000000, 2'd0, 3'd0, 2'b00, 1'b0, "R1");   // 2.5 nearest
    check("R1", "2.5 nearest-even", out_res, 64'd2);
    check("R1", "2.5 inexact", {63'b0, out_inexact}, 64'd1);
    run(64'h400C000000000000, 2'd0, 3'd0, 2'b00, 1'b0, "R1");   // 3.5 nearest
    check("R1", "3.5 nearest-even", out_res, 64'd4);
    check("R1", "3.5 rounded-up", {63'b0, out_rnd_up}, 64'd1);
    run(64'hC004000000000000, 2'd2, 3'd0, 2'b10, 1'b0, "R1");   // -2.5 ceil
    check("R1", "-2.5 ceiling", out_res, 64'hFFFFFFFFFFFFFFFE);
    run(64'hC004000000000000, 2'd2, 3'd0, 2'b11, 1'b0, "R1");   // -2.5 floor
    check("R1", "-2.5 floor", out_res, 64'hFFFFFFFFFFFFFFFD);
    run(64'h400599999999999A, 2'd0, 3'd4, 2'b00, 1'b0, "R1");   // 2.7, mode bit 2 truncates
    check("R1", "2.7 forced truncation", out_res, 64'd2);

    // R2 extension
    run(64'hBFF0000000000000, 2'd0, 3'd0, 2'b00, 1'b0, "R2");
    check("R2", "-1 s32 sign-extended", out_res, 64'hFFFFFFFFFFFFFFFF);
    run(64'h41EFFFFFFFE00000, 2'd1, 3'd0, 2'b00, 1'b0, "R2");
    check("R2", "2^32-1 u32 zero-extended", out_res, 64'h00000000FFFFFFFF);

    // R3 saturation
    run(64'h4202A05F20000000, 2'd0, 3'd0, 2'b00, 1'b0, "R3");
    check("R3", "1e10 s32 clamps high", out_res, 64'h000000007FFFFFFF);
    check("R6", "1e10 s32 overflow", {63'b0, out_ovf}, 64'd1);
    run(64'hC014000000000000, 2'd3, 3'd2, 2'b00, 1'b0, "R3");
    check("R3", "-5 u64 clamps low", out_res, 64'd0);
    run(64'hFFF0000000000000, 2'd2, 3'd1, 2'b00, 1'b0, "R3");
    check("R3", "-inf s64", out_res, 64'h8000000000000000);

    // R4 NaN
    run(64'h7FF8000000000000, 2'd2, 3'd0, 2'b00, 1'b0, "R4");
    check("R4", "NaN mode 0", out_res, 64'h8000000000000000);
    run(64'h7FF8000000000000, 2'd0, 3'd3, 2'b00, 1'b0, "R4");
    check("R4", "NaN mode 3", out_res, 64'd0);

    // R5 wrap
    run(64'h4270000000003000, 2'd0, 3'd4, 2'b00, 1'b0, "R5");
    check("R5", "2^40+3 s32 wraps", out_res, 64'd3);
    check("R6", "wrap overflow", {63'b0, out_inv_cvt}, 64'd1);
    run(64'hC1F0000000500000, 2'd1, 3'd5, 2'b00, 1'b0, "R5");
    check("R5", "-(2^32+5) u32 wraps", out_res, 64'h00000000FFFFFFFB);
    run(64'h47F0000000000000, 2'd3, 3'd4, 2'b00, 1'b0, "R5");
    check("R5", "2^128 gives zero", out_res, 64'd0);
    run(64'h47EFFFFFFFFFFFFF, 2'd2, 3'd4, 2'b00, 1'b0, "R5");
    check("R5", "just under 2^128 low bits", out_res, 64'd0);

    // R8 / R9 signaling NaN and trap
    run(64'h4004000000000000, 2'd2, 3'd0, 2'b00, 1'b0, "R9");   // sets held value 2
    run(64'h7FF0000000000001, 2'd2, 3'd0, 2'b00, 1'b1, "R9");
    check("R8", "signaling NaN flag", {63'b0, out_inv_snan}, 64'd1);
    check("R9", "trap keeps result", out_res, 64'd2);
    check("R9", "trap no write", {63'b0, out_we}, 64'd0);
    idle_check();
    run(64'h4004000000000000, 2'd0, 3'd0, 2'b00, 1'b1, "R9");   // inexact only: still written
    check("R9", "inexact not trapped", {63'b0, out_we}, 64'd1);

    // R10 illegal mode
    run(64'h3FF0000000000000, 2'd2, 3'd6, 2'b00, 1'b0, "R10");
    check("R10", "mode 6 bad", {63'b0, out_bad_mode}, 64'd1);
    run(64'h7FF0000000000001, 2'd0, 3'd7, 2'b00, 1'b0, "R10");
    check("R10", "mode 7 no snan flag", {63'b0, out_inv_snan}, 64'd0);
    idle_check();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] op;
      logic [2:0] md;
      string tg;
      op = gen_op();
      md = 3'($urandom % 8);
      tg = (md[2:1] == 2'b11) ? "R10" :
           ((op[62:52] == 11'h7FF) && (op[51:0] != 0)) ? "R4" :
           md[2] ? "R5" : "R3";
      run(op, 2'($urandom % 4), md, 2'($urandom % 4), ($urandom % 4) == 0, tg);
      if (i % 97 == 0) idle_check();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule